// File: doc/BRIEF.md
# Three-Wire Serial Register Interface

This block is the slave side of a serial link made of a chip select, a serial clock and one data line that carries traffic both ways. It gives a host access to a 7-bit register address space. Every transfer is two bytes long: a command byte followed by one data byte. The command byte carries the register address and a direction flag. The data byte is either shifted in and written to the register file, or fetched from the register file and shifted back out on the same line.

All link pins are oversampled in the system clock domain. The meaning of the registers lives outside this block. The register file connects through a registered hook: one strobe and address for a read, with data expected one cycle later, and one strobe, address and data for a write. A write-protect level comes from the register file and blocks every write while it is high. The upper part of the address space is reserved. After reset the block stays deaf for a programmable number of cycles. Once that delay has passed, it still waits for a fresh rising edge of chip select before it accepts a transfer.

Top module: `tw_regif`

## Requirements
- R1: While reset is high, and on the first cycle after it, `sdio_oe`, `reg_wr` and `reg_rd` are 0.
- R2: While `cs` is low, toggling `sclk` and `sdio_in` causes no register access and leaves `sdio_oe` at 0.
- R3: `sdio_in` is sampled on rising `sclk` edges, least significant bit first. The first 8 bits form the command: bits 0 to 6 are the address, and bit 7 is the direction (1 = write, 0 = read).
- R4: For a write to a non-reserved address, after the 16th rising edge the block raises `reg_wr` for exactly one cycle. It presents the command address on `reg_addr` and the second byte, assembled least significant bit first, on `reg_wdata`.
- R5: For a read of a non-reserved address, the block pulses `reg_rd` with the address and takes `reg_rdata` one cycle later. Bit 0 of the data is on `sdio_out` before the 9th rising edge, and each following bit appears after the next falling edge.
- R6: `sdio_oe` is 0 during the command byte, is 1 from the first data bit of a read, and returns to 0 within 4 clock cycles after `cs` falls.
- R7: A read of address 0Fh to 7Fh returns 00h and raises no `reg_rd`.
- R8: A write to address 0Fh to 7Fh raises no `reg_wr`.
- R9: While `wp` is 1 at the end of the data byte, no write is issued to any address. The previous register contents remain readable afterwards.
- R10: If `cs` falls before the 16th rising edge of a write, no write is issued.
- R11: During the first `PWRUP_CYCLES` cycles after reset, transfers are ignored. A transfer whose `cs` rose before that delay ended is also ignored until `cs` goes low and high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, high during a transfer |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Data line as seen by the block |
| sdio_out | output | 1 | Data driven onto the line during a read |
| sdio_oe | output | 1 | Output enable for the data line |
| wp | input | 1 | Write-protect level from the register file |
| reg_addr | output | 7 | Register address for the hook |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |

## Verification
A wrong bit counter or a wrong shift direction shows up as a wrong `reg_addr` or `reg_wdata` at the write strobe. It is visible on that same transfer, about three clocks after the 16th rising edge. A read shifter that is misaligned by one bit corrupts the byte the host assembles within the same frame. A stale frame phase appears as a stray write strobe or an output enable that stays high more than four clocks after chip select falls. A broken reserved-range or protect decode appears as an unexpected strobe on the very transfer that should be refused.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CMD,
    PH_DATA,
    PH_DONE
  } tw_phase_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int N_SIG  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SIG-1:0] din,
  output logic [N_SIG-1:0] sync_q,
  output logic [N_SIG-1:0] prev_q
);
  for (genvar g = 0; g < N_SIG; g++) begin : g_sig
    logic [STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-1:0], din[g]};
    end
    assign sync_q[g] = chain[STAGES-1];
    assign prev_q[g] = chain[STAGES];
  end
endmodule

// File: rtl/tw_pwrup.sv
module tw_pwrup #(
  parameter int CYCLES = 256
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      if (cnt != LAST) cnt <= cnt + 1'b1;
      ready <= (cnt == LAST);
    end
  end

  p_ready_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import tw_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready,
  input  logic              cs_q,
  input  logic              cs_p,
  input  logic              sck_q,
  input  logic              sck_p,
  input  logic              sd_q,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              cmd_done,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wr_done,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdio_out,
  output logic              sdio_oe
);
  localparam int CMD_BITS = ADDR_W + 1;
  localparam int TOTAL    = CMD_BITS + DATA_W;
  localparam int CNT_W    = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] CMD_END   = CNT_W'(CMD_BITS);

  tw_phase_e           phase;
  logic [CNT_W-1:0]    cnt;
  logic [CMD_BITS-1:0] cmd_sh;
  logic [DATA_W-1:0]   dat_sh;
  logic [DATA_W-1:0]   tx_sh;
  logic                sck_rise, sck_fall, cs_rise;
  logic [CMD_BITS-1:0] cmd_next;
  logic [DATA_W-1:0]   dat_next;

  assign sck_rise = sck_q & ~sck_p;
  assign sck_fall = ~sck_q & sck_p;
  assign cs_rise  = cs_q & ~cs_p;
  assign cmd_next = {sd_q, cmd_sh[CMD_BITS-1:1]};
  assign dat_next = {sd_q, dat_sh[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      cmd_sh   <= '0;
      dat_sh   <= '0;
      cmd_done <= 1'b0;
      cmd_wr   <= 1'b0;
      cmd_addr <= '0;
      wr_done  <= 1'b0;
      wr_data  <= '0;
    end else begin
      cmd_done <= 1'b0;
      wr_done  <= 1'b0;
      if (!cs_q) begin
        phase <= PH_IDLE;
        cnt   <= '0;
      end else begin
        unique case (phase)
          PH_IDLE: if (cs_rise && ready) begin
            phase <= PH_CMD;
            cnt   <= '0;
          end
          PH_CMD: if (sck_rise) begin
            cmd_sh <= cmd_next;
            cnt    <= cnt + 1'b1;
            if (cnt == CMD_LAST) begin
              cmd_wr   <= cmd_next[CMD_BITS-1];
              cmd_addr <= cmd_next[ADDR_W-1:0];
              cmd_done <= 1'b1;
              phase    <= PH_DATA;
            end
          end
          PH_DATA: if (sck_rise) begin
            dat_sh <= dat_next;
            cnt    <= cnt + 1'b1;
            if (cnt == DATA_LAST) begin
              wr_done <= cmd_wr;
              wr_data <= dat_next;
              phase   <= PH_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Read shifter: first bit appears on load, later bits after each falling
  // edge that follows a data-phase rising edge.
  always_ff @(posedge clk) begin
    if (rst || !cs_q || phase == PH_IDLE) begin
      tx_sh    <= '0;
      sdio_out <= 1'b0;
      sdio_oe  <= 1'b0;
    end else if (load) begin
      tx_sh    <= load_data;
      sdio_out <= load_data[0];
      sdio_oe  <= 1'b1;
    end else if (sck_fall && sdio_oe && phase == PH_DATA && cnt > CMD_END) begin
      tx_sh    <= tx_sh >> 1;
      sdio_out <= tx_sh[1];
    end
  end

  p_oe_release_r6: assert property (@(posedge clk) disable iff (rst)
    !cs_q |=> !sdio_oe);
  p_oe_not_in_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CMD) |-> !sdio_oe);
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(TOTAL));
  p_full_byte_r10: assert property (@(posedge clk) disable iff (rst)
    wr_done |-> (phase == PH_DONE) && $past(phase == PH_DATA));
endmodule

// File: rtl/tw_regif.sv
module tw_regif #(
  parameter int ADDR_W       = 7,
  parameter int DATA_W       = 8,
  parameter int RESV_BASE    = 15,
  parameter int PWRUP_CYCLES = 256,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              sclk,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  input  logic              wp,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata
);
  localparam logic [ADDR_W-1:0] RESV_A = ADDR_W'(RESV_BASE);

  logic [2:0]        pin_q, pin_p;
  logic              ready;
  logic              cmd_done, cmd_wr, wr_done;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] wr_data;
  logic              load, rd_wait;
  logic [DATA_W-1:0] load_data;
  logic              addr_ok;

  tw_sync #(.N_SIG(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    ({sdio_in, sclk, cs}),
    .sync_q (pin_q),
    .prev_q (pin_p)
  );

  tw_pwrup #(.CYCLES(PWRUP_CYCLES)) u_pwrup (
    .clk   (clk),
    .rst   (rst),
    .ready (ready)
  );

  tw_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .cs_q      (pin_q[0]),
    .cs_p      (pin_p[0]),
    .sck_q     (pin_q[1]),
    .sck_p     (pin_p[1]),
    .sd_q      (pin_q[2]),
    .load      (load),
    .load_data (load_data),
    .cmd_done  (cmd_done),
    .cmd_wr    (cmd_wr),
    .cmd_addr  (cmd_addr),
    .wr_done   (wr_done),
    .wr_data   (wr_data),
    .sdio_out  (sdio_out),
    .sdio_oe   (sdio_oe)
  );

  assign addr_ok = (cmd_addr < RESV_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_addr  <= '0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      rd_wait   <= 1'b0;
      load      <= 1'b0;
      load_data <= '0;
    end else begin
      reg_rd  <= 1'b0;
      reg_wr  <= 1'b0;
      load    <= 1'b0;
      rd_wait <= reg_rd;
      if (cmd_done && !cmd_wr) begin
        if (addr_ok) begin
          reg_rd   <= 1'b1;
          reg_addr <= cmd_addr;
        end else begin
          load      <= 1'b1;
          load_data <= '0;
        end
      end
      if (rd_wait) begin
        load      <= 1'b1;
        load_data <= reg_rdata;
      end
      if (wr_done && addr_ok && !wp) begin
        reg_wr    <= 1'b1;
        reg_addr  <= cmd_addr;
        reg_wdata <= wr_data;
      end
    end
  end

  p_rsv_no_read_r7: assert property (@(posedge clk) disable iff (rst)
    reg_rd |-> reg_addr < RESV_A);
  p_rsv_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> reg_addr < RESV_A);
  p_wp_block_r9: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> !$past(wp));
  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);
  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !reg_wr && !reg_rd && !sdio_oe);
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));
endmodule

// File: tb/sim_tw_regif.sv
module sim_tw_regif;
  localparam int PWR = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sclk = 1'b0, sdio_in = 1'b0, wp = 1'b0;
  logic sdio_out, sdio_oe, reg_rd, reg_wr;
  logic [6:0] reg_addr;
  logic [7:0] reg_rdata = '0, reg_wdata;

  always #2.5 clk = ~clk;

  tw_regif #(.PWRUP_CYCLES(PWR)) u0 (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .wp(wp),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata)
  );

  int checks = 0, errors = 0, wr_seen = 0, rd_seen = 0;
  logic finished = 1'b0;
  string cur_req = "R1";
  logic [14:0] exp_q[$];
  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];

  // register file model with one-cycle read latency
  always @(posedge clk) begin
    if (reg_wr) mem[reg_addr] <= reg_wdata;
    if (reg_rd) reg_rdata <= mem[reg_addr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes as they appear
  always @(negedge clk) begin
    if (!rst && reg_rd) rd_seen++;
    if (!rst && reg_wr) begin
      wr_seen++;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL %s actual write %0h:%0h expected none", cur_req, reg_addr, reg_wdata);
      end else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        chk(cur_req, {17'd0, reg_addr, reg_wdata}, {17'd0, e});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] wd, input int nbits,
                      output logic [7:0] rd);
    rd = '0;
    cs = 1'b1;
    wait_clk(8);
    for (int i = 0; i < nbits; i++) begin
      sdio_in = (i < 8) ? cmd[i] : wd[i-8];
      sclk = 1'b0;
      wait_clk(8);
      if (i >= 8) rd[i-8] = sdio_out;
      if (!cmd[7] && i == 7) chk("R6", {31'd0, sdio_oe}, 32'd0);
      if (!cmd[7] && i == 8) chk("R6", {31'd0, sdio_oe}, 32'd1);
      sclk = 1'b1;
      wait_clk(8);
    end
    sclk = 1'b0;
    wait_clk(8);
    cs = 1'b0;
    wait_clk(5);
    chk("R6", {31'd0, sdio_oe}, 32'd0);
    wait_clk(3);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input logic expect_it);
    logic [7:0] unused;
    if (expect_it) begin
      exp_q.push_back({a, d});
      exp_mem[a] = d;
    end
    xfer({1'b1, a}, d, 16, unused);
    wait_clk(4);
  endtask

  task automatic do_read(input logic [6:0] a, input string req);
    logic [7:0] got;
    xfer({1'b0, a}, 8'h00, 16, got);
    chk(req, {24'd0, got}, {24'd0, (a < 7'h0F) ? exp_mem[a] : 8'h00});
  endtask

  initial begin
    int w0, r0;
    logic [7:0] unused;
    for (int i = 0; i < 128; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    wait_clk(3);
    chk("R1", {29'd0, sdio_oe, reg_wr, reg_rd}, 32'd0);
    rst = 1'b0;
    wait_clk(1);
    chk("R1", {29'd0, sdio_oe, reg_wr, reg_rd}, 32'd0);

    // R11: transfer starting inside the power-up delay is dropped
    cur_req = "R11";
    xfer({1'b1, 7'h03}, 8'h55, 16, unused);
    wait_clk(4);
    chk("R11", wr_seen, 0);
    do_read(7'h03, "R11");

    // R3 / R4: plain writes, LSB first
    cur_req = "R4";
    do_write(7'h02, 8'hA5, 1'b1);
    do_write(7'h00, 8'h3C, 1'b1);
    do_write(7'h0E, 8'h81, 1'b1);
    chk("R3", wr_seen, 3);
    // R5: reads back
    do_read(7'h02, "R5");
    do_read(7'h0E, "R5");
    do_read(7'h00, "R5");
    chk("R5", rd_seen, 4);

    // R2: clocking with chip select low
    cur_req = "R2";
    w0 = wr_seen; r0 = rd_seen;
    for (int i = 0; i < 16; i++) begin
      sdio_in = i[0];
      sclk = 1'b0; wait_clk(8);
      sclk = 1'b1; wait_clk(8);
      chk("R2", {31'd0, sdio_oe}, 32'd0);
    end
    sclk = 1'b0; wait_clk(8);
    chk("R2", wr_seen + rd_seen, w0 + r0);

    // R8 / R7: reserved range
    cur_req = "R8";
    w0 = wr_seen;
    do_write(7'h0F, 8'hFF, 1'b0);
    do_write(7'h7F, 8'h12, 1'b0);
    chk("R8", wr_seen, w0);
    cur_req = "R7";
    r0 = rd_seen;
    do_read(7'h0F, "R7");
    do_read(7'h7F, "R7");
    chk("R7", rd_seen, r0);

    // R9: write protect, including the control address
    cur_req = "R9";
    wp = 1'b1;
    w0 = wr_seen;
    do_write(7'h02, 8'h11, 1'b0);
    do_write(7'h0D, 8'h00, 1'b0);
    chk("R9", wr_seen, w0);
    wp = 1'b0;
    do_read(7'h02, "R9");
    do_read(7'h0D, "R9");

    // R10: aborted write
    cur_req = "R10";
    w0 = wr_seen;
    xfer({1'b1, 7'h05}, 8'h77, 12, unused);
    xfer({1'b1, 7'h05}, 8'h77, 15, unused);
    chk("R10", wr_seen, w0);
    do_read(7'h05, "R10");

    // R6: aborted read releases the line
    xfer({1'b0, 7'h02}, 8'h00, 11, unused);

    chk("R4", exp_q.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule